// File: doc/BRIEF.md
# Dual-role SPI controller with double-buffered receive

This block is a byte-wide SPI peripheral that a processor reaches through two addresses: a data address and an 8-bit control register. It runs either as the bus master, generating SCLK itself, or as a slave clocked by an external master. A write to the data address loads the shift register that feeds SDO. A read from the same address returns a separate receive buffer. Each finished byte is copied into that buffer, so the next byte can start shifting in before software has collected the last one.

In master mode a data write starts an 8-bit, MSB-first transfer. SCLK half-periods are timed either by a divider on the system clock or by rising edges of an external timer output. In slave mode, the incoming SCLK, select and data lines pass through two-flop synchronisers before use. The slave-select polarity is programmable, the SDO driver has its own enable, and receive-available and overrun flags are kept, with an interrupt request raised while a byte waits.

Control register bits: bit0 enable, bit1 divider LSB (master) or overrun flag (slave), bit2 divider MSB (master) or SDO enable (slave), bit3 select polarity, bit4 receive-available (read only), bit5 clock polarity, bit6 clock source, bit7 master (1) or slave (0).

Top module: `spi_dual_role`

## Requirements
- R1: After reset the control register reads 0x00, the data address reads 0x00, and irq, sdo_oe and sclk_oe are all low.
- R2: addr=0 is the data address. A write there loads the transmit shift register. A read there returns the receive buffer, never the value last written.
- R3: In master mode with bit0=1, a data write starts a transfer. Bits leave on sdo_o MSB first, one per SCLK period, and the 8 bits sampled from sdi_i are placed in the receive buffer.
- R4: With bit6=0, every SCLK half-period lasts 2^bits[2:1] system clocks, which gives SCLK = clk/2, /4, /8 or /16. The first edge comes that many clocks after the write.
- R5: With bit6=1, each rising edge of tmr_in, after synchronisation, produces exactly one SCLK edge.
- R6: SCLK idles at the level of bit5. With bit5=0, data is sampled on rising edges and driven on falling edges. With bit5=1, the edges are swapped. The same rule applies in slave mode.
- R7: Control bit4 is set when a byte completes and cleared by a data read. If a read and a completion fall in the same cycle, the read returns the old byte and the flag stays set, with the new byte in the buffer.
- R8: irq is high exactly while the receive-available flag and irq_en are both high.
- R9: A byte that completes while the flag is set and no read is in that cycle is dropped, and the buffer keeps the old byte. In slave mode this event sets control bit1. Writing 0 to bit1 clears it, and writing 1 leaves it unchanged.
- R10: In slave mode, bytes are received and sent only while ss_i is at its active level: low when bit3=0, high when bit3=1. Bits clocked while ss_i is inactive are ignored.
- R11: In slave mode, sdo_oe is high only while the select is active and bit2=1. In master mode with bit0=1, sdo_oe and sclk_oe are high.
- R12: In slave mode, deasserting the select abandons a partial byte. The next selected transfer receives a full fresh byte, and the partial byte never sets the flag.
- R13: With bit0=0 no transfer starts and SCLK does not toggle. A data write during a running master transfer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (data read clears the available flag) |
| addr | input | 1 | 0 selects data, 1 selects control |
| wdata | input | DW | Write data; control uses bits 7:0 |
| rdata | output | DW | Read data for the selected address |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Receive interrupt request |
| tmr_in | input | 1 | External timer output used as SCLK timing source |
| sclk_o | output | 1 | SCLK driven in master mode |
| sclk_oe | output | 1 | SCLK driver enable |
| sclk_i | input | 1 | SCLK received in slave mode |
| ss_i | input | 1 | Slave select input |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | SDO driver enable (low means tristate) |
| sdi_i | input | 1 | Serial data in |

## Verification
The case that needs care is a data read landing in the same cycle as a byte completion. Both update the receive-available flag and the receive buffer. The bench provokes it in master mode at the /2 divider, where completion falls exactly 16 clocks after the capturing write. It leaves the previous byte unread and strobes the read in that 16th cycle. The result is correct if the read returns the old byte, the flag stays set, the new byte can be read next, and no byte is lost as an overrun.

// File: rtl/spi_dual_role.sv
module spi_dual_role #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          irq_en,
  output logic          irq,
  input  logic          tmr_in,
  output logic          sclk_o,
  output logic          sclk_oe,
  input  logic          sclk_i,
  input  logic          ss_i,
  output logic          sdo_o,
  output logic          sdo_oe,
  input  logic          sdi_i
);
  localparam int BW = $clog2(DW);
  localparam int EW = $clog2(2*DW);
  localparam int VW = 4;

  logic [7:5]    ctrl_hi;
  logic [3:0]    ctrl_lo;
  logic          avail_q, ovr_q, busy_q, samp_q;
  logic [DW-1:0] sr_q, rxbuf_q;
  logic [EW-1:0] edge_q;
  logic [BW-1:0] bit_q;
  logic [VW-1:0] div_q;
  logic [2:0]    tmr_s, sclk_s;
  logic [1:0]    sdi_s, ss_s;

  logic en, master, cpol, src, sspol, oe_bit;
  assign en     = ctrl_lo[0];
  assign oe_bit = ctrl_lo[2];
  assign sspol  = ctrl_lo[3];
  assign cpol   = ctrl_hi[5];
  assign src    = ctrl_hi[6];
  assign master = ctrl_hi[7];

  logic data_wr, ctrl_wr, data_rd;
  assign data_wr = wr_en && !addr;
  assign ctrl_wr = wr_en && addr;
  assign data_rd = rd_en && !addr;

  logic [VW-1:0] half_m1;
  assign half_m1 = (VW'(1) << ctrl_lo[2:1]) - VW'(1);

  logic tmr_rise, tick, start, m_sample, m_shift, m_done;
  assign tmr_rise = tmr_s[1] & ~tmr_s[2];
  assign tick     = busy_q && (src ? tmr_rise : (div_q == half_m1));
  assign start    = data_wr && master && en && !busy_q;
  assign m_sample = tick && !edge_q[0];
  assign m_shift  = tick && edge_q[0];
  assign m_done   = m_shift && (edge_q == EW'(2*DW-1));

  logic ss_act, s_on, sc_rise, sc_fall, s_sample, s_shift, s_done;
  assign ss_act   = (ss_s[1] == sspol);
  assign s_on     = en && !master && ss_act;
  assign sc_rise  = sclk_s[1] & ~sclk_s[2];
  assign sc_fall  = ~sclk_s[1] & sclk_s[2];
  assign s_sample = s_on && (cpol ? sc_fall : sc_rise);
  assign s_shift  = s_on && (cpol ? sc_rise : sc_fall);
  assign s_done   = s_sample && (bit_q == BW'(DW-1));

  logic          done, keep;
  logic [DW-1:0] new_byte;
  assign done     = m_done || s_done;
  assign keep     = avail_q && !data_rd;
  assign new_byte = m_done ? {sr_q[DW-2:0], samp_q} : {sr_q[DW-2:0], sdi_s[1]};

  logic [7:0] ctrl_view;
  assign ctrl_view = {ctrl_hi, avail_q, ctrl_lo[3:2], master ? ctrl_lo[1] : ovr_q, ctrl_lo[0]};

  assign rdata   = addr ? DW'(ctrl_view) : rxbuf_q;
  assign irq     = avail_q && irq_en;
  assign sclk_o  = cpol ^ edge_q[0];
  assign sclk_oe = en && master;
  assign sdo_o   = sr_q[DW-1];
  assign sdo_oe  = en && (master || (ss_act && oe_bit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_hi <= '0;
      ctrl_lo <= '0;
      avail_q <= 1'b0;
      ovr_q   <= 1'b0;
      busy_q  <= 1'b0;
      samp_q  <= 1'b0;
      sr_q    <= '0;
      rxbuf_q <= '0;
      edge_q  <= '0;
      bit_q   <= '0;
      div_q   <= '0;
      tmr_s   <= '0;
      sclk_s  <= '0;
      sdi_s   <= '0;
      ss_s    <= '0;
    end else begin
      tmr_s  <= {tmr_s[1:0], tmr_in};
      sclk_s <= {sclk_s[1:0], sclk_i};
      sdi_s  <= {sdi_s[0], sdi_i};
      ss_s   <= {ss_s[0], ss_i};

      if (ctrl_wr) begin
        ctrl_hi <= wdata[7:5];
        ctrl_lo <= wdata[3:0];
      end

      if (!en || !master) begin
        busy_q <= 1'b0;
        edge_q <= '0;
        div_q  <= '0;
      end else if (start) begin
        busy_q <= 1'b1;
        edge_q <= '0;
        div_q  <= '0;
      end else if (busy_q) begin
        if (!src) div_q <= (div_q == half_m1) ? '0 : div_q + VW'(1);
        if (tick) begin
          edge_q <= m_done ? '0 : edge_q + EW'(1);
          if (m_done) busy_q <= 1'b0;
        end
      end

      if (!s_on) bit_q <= '0;
      else if (s_sample) bit_q <= s_done ? '0 : bit_q + BW'(1);

      if (m_sample) samp_q <= sdi_i;
      else if (s_sample) samp_q <= sdi_s[1];

      if (data_wr && !(master && busy_q)) sr_q <= wdata;
      else if (m_shift || s_shift) sr_q <= {sr_q[DW-2:0], samp_q};

      if (ctrl_wr && !master && !wdata[1]) ovr_q <= 1'b0;

      if (done) begin
        avail_q <= 1'b1;
        if (keep) begin
          if (!master) ovr_q <= 1'b1;
        end else begin
          rxbuf_q <= new_byte;
        end
      end else if (data_rd) begin
        avail_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_dual_role_chk.sv
module spi_dual_role_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          data_rd,
  input logic          avail_q,
  input logic          ovr_q,
  input logic [DW-1:0] rxbuf_q,
  input logic          irq,
  input logic          irq_en,
  input logic          busy_q,
  input logic          master,
  input logic          en,
  input logic          cpol,
  input logic          sclk_o
);
  assert_done_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> avail_q);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !done) |=> !avail_q);

  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(done) || (irq_en && !$past(irq_en))));

  assert_ovr_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(done && avail_q));

  assert_drop_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && avail_q && !data_rd) |=> $stable(rxbuf_q));

  assert_idle_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && master && en) |-> (sclk_o == cpol));

  assert_disable_stops_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy_q);
endmodule

bind spi_dual_role spi_dual_role_chk #(.DW(DW)) u_spi_dual_role_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .done    (done),
  .data_rd (data_rd),
  .avail_q (avail_q),
  .ovr_q   (ovr_q),
  .rxbuf_q (rxbuf_q),
  .irq     (irq),
  .irq_en  (irq_en),
  .busy_q  (busy_q),
  .master  (master),
  .en      (en),
  .cpol    (cpol),
  .sclk_o  (sclk_o)
);

// File: tb/test_spi_dual_role.sv
`timescale 1ns/1ps
module test_spi_dual_role;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, irq_en = 1'b0;
  logic tmr_in = 1'b0, sclk_i = 1'b0, ss_i = 1'b1, sdi_i = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq, sclk_o, sclk_oe, sdo_o, sdo_oe;
  int n_chk = 0, n_bad = 0;
  bit tmr_run = 1'b0;

  always #2.5 clk = ~clk;

  spi_dual_role i_spi_dual_role (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_en(irq_en), .irq(irq), .tmr_in(tmr_in),
    .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sclk_i(sclk_i), .ss_i(ss_i),
    .sdo_o(sdo_o), .sdo_oe(sdo_oe), .sdi_i(sdi_i)
  );

  initial forever begin
    repeat (5) @(negedge clk);
    tmr_in = tmr_run ? ~tmr_in : 1'b0;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ctl(bit ms, bit src, bit pol, bit ssp, bit b2, bit b1, bit en);
    return {ms, src, pol, 1'b0, ssp, b2, b1, en};
  endfunction

  function automatic logic [7:0] ctrl_exp(logic [7:0] w, bit av, bit ov);
    return w[7] ? {w[7:5], av, w[3:0]} : {w[7:5], av, w[3:2], ov, w[0]};
  endfunction

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic m_xfer(input logic [7:0] c, input logic [7:0] tx, input logic [7:0] rx,
                        input bit inject, output logic [7:0] got);
    int k = 0, gap = 0, tmo = 0, badgap = 0, hexp;
    logic prev;
    hexp = c[6] ? 10 : (1 << c[2:1]);
    wr(1'b1, c);
    chk("R6 idle level before", sclk_o, c[5]);
    sdi_i = rx[7];
    wr(1'b0, tx);
    prev = sclk_o; got = '0;
    while (k < 16 && tmo < 4000) begin
      @(negedge clk); tmo++; gap++;
      wr_en = 1'b0;
      if (sclk_o !== prev) begin
        k++; prev = sclk_o;
        if ((!c[6] || k > 1) && gap != hexp) badgap++;
        gap = 0;
        if (k % 2 == 1) got = {got[6:0], sdo_o};
        else if (k < 16) sdi_i = rx[7 - k/2];
        if (inject && k == 4) begin wr_en = 1'b1; addr = 1'b0; wdata = ~tx; end
      end
    end
    wr_en = 1'b0;
    chk(c[6] ? "R5 timer edge spacing" : "R4 divider edge spacing", badgap, 0);
    chk("R6 idle level after", sclk_o, c[5]);
  endtask

  task automatic s_setup(input logic [7:0] c);
    wr(1'b1, 8'h00);
    ss_i = ~c[3]; sclk_i = c[5];
    repeat (4) @(negedge clk);
    wr(1'b1, c);
    repeat (3) @(negedge clk);
  endtask

  task automatic s_xfer(input logic [7:0] c, input logic [7:0] mb, input int nbits,
                        input bit sel, output logic [7:0] got, output logic oe_seen);
    ss_i = sel ? c[3] : ~c[3];
    repeat (6) @(negedge clk);
    oe_seen = sdo_oe; got = '0;
    for (int i = 0; i < nbits; i++) begin
      sdi_i = mb[7-i];
      repeat (6) @(negedge clk);
      got = {got[6:0], sdo_o};
      sclk_i = ~c[5];
      repeat (6) @(negedge clk);
      sclk_i = c[5];
    end
    repeat (6) @(negedge clk);
    ss_i = ~c[3];
    repeat (6) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v, got, c, tx, rx, old;
    logic oe;
    int toggles;

    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 sdo_oe", sdo_oe, 0);
    chk("R1 sclk_oe", sclk_oe, 0);
    rd(1'b1, v); chk("R1 control", v, 8'h00);
    rd(1'b0, v); chk("R1 data", v, 8'h00);

    // R13 disabled master does nothing
    c = ctl(1, 0, 0, 0, 0, 0, 0);
    wr(1'b1, c); wr(1'b0, 8'hA5);
    toggles = 0; v = sclk_o;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sclk_o !== v) begin toggles++; v = sclk_o; end
    end
    chk("R13 no SCLK when disabled", toggles, 0);
    rd(1'b1, v); chk("R13 no completion when disabled", v, ctrl_exp(c, 0, 0));

    // R3 R4 directed master /2, polarity 0
    c = ctl(1, 0, 0, 0, 0, 0, 1);
    m_xfer(c, 8'hA5, 8'h3C, 0, got);
    chk("R3 master sdo byte", got, 8'hA5);
    chk("R11 master drives", {sdo_oe, sclk_oe}, 2'b11);
    rd(1'b1, v); chk("R7 available after done", v, ctrl_exp(c, 1, 0));
    irq_en = 1'b1; #1;
    chk("R8 irq with flag and enable", irq, 1);
    rd(1'b0, v); chk("R2 R3 receive buffer", v, 8'h3C);
    #1 chk("R8 irq drops after read", irq, 0);
    rd(1'b1, v); chk("R7 cleared by read", v, ctrl_exp(c, 0, 0));

    // R13 write during transfer ignored, /16, polarity 1
    c = ctl(1, 0, 1, 0, 1, 1, 1);
    m_xfer(c, 8'h81, 8'h7E, 1, got);
    chk("R13 busy write ignored", got, 8'h81);
    rd(1'b0, v); chk("R3 receive /16 polarity 1", v, 8'h7E);

    // R5 timer source
    tmr_run = 1'b1;
    c = ctl(1, 1, 0, 0, 0, 0, 1);
    m_xfer(c, 8'h5C, 8'hC3, 0, got);
    chk("R5 timer sdo byte", got, 8'h5C);
    rd(1'b0, v); chk("R5 timer receive", v, 8'hC3);
    tmr_run = 1'b0;

    // R7 read and completion in the same cycle
    c = ctl(1, 0, 0, 0, 0, 0, 1);
    m_xfer(c, 8'h11, 8'h22, 0, got);
    sdi_i = 1'b1;
    wr(1'b0, 8'hF0);
    repeat (15) @(negedge clk);
    rd_en = 1'b1; addr = 1'b0;
    #1 old = rdata;
    @(negedge clk); rd_en = 1'b0;
    chk("R7 collision read returns old", old, 8'h22);
    chk("R8 irq held through collision", irq, 1);
    rd(1'b1, v); chk("R7 collision flag stays", v, ctrl_exp(c, 1, 0));
    rd(1'b0, v); chk("R7 collision new byte kept", v, 8'hFF);

    // R9 master drop
    m_xfer(c, 8'h00, 8'h44, 0, got);
    m_xfer(c, 8'h00, 8'h55, 0, got);
    rd(1'b0, v); chk("R9 master drop keeps old", v, 8'h44);
    irq_en = 1'b0;

    // random master
    for (int n = 0; n < 24; n++) begin
      c  = ctl(1, 0, 1'($urandom), 0, 1'($urandom), 1'($urandom), 1);
      tx = 8'($urandom); rx = 8'($urandom);
      m_xfer(c, tx, rx, 0, got);
      chk("R3 R4 random master sdo", got, tx);
      rd(1'b1, v); chk("R7 random master flag", v, ctrl_exp(c, 1, 0));
      rd(1'b0, v); chk("R2 random master receive", v, rx);
    end

    // R10 R11 slave, select active low
    c = ctl(0, 0, 0, 0, 1, 0, 1);
    s_setup(c);
    wr(1'b0, 8'hC6);
    chk("R11 tristate while deselected", sdo_oe, 0);
    s_xfer(c, 8'h9A, 8, 1, got, oe);
    chk("R11 driven while selected", oe, 1);
    chk("R10 slave sdo byte", got, 8'hC6);
    rd(1'b1, v); chk("R7 slave flag", v, ctrl_exp(c, 1, 0));
    rd(1'b0, v); chk("R2 R10 slave receive", v, 8'h9A);

    // R11 output enable off
    c = ctl(0, 0, 0, 0, 0, 0, 1);
    s_setup(c);
    wr(1'b0, 8'h3F);
    s_xfer(c, 8'h66, 8, 1, got, oe);
    chk("R11 tristate with enable off", oe, 0);
    rd(1'b0, v); chk("R10 receive with sdo off", v, 8'h66);

    // R10 inactive select ignored, active high polarity
    c = ctl(0, 0, 1, 1, 1, 0, 1);
    s_setup(c);
    s_xfer(c, 8'hE7, 8, 0, got, oe);
    rd(1'b1, v); chk("R10 deselected bits ignored", v, ctrl_exp(c, 0, 0));
    wr(1'b0, 8'h2D);
    s_xfer(c, 8'hB4, 8, 1, got, oe);
    chk("R10 active high sdo", got, 8'h2D);
    rd(1'b0, v); chk("R10 active high receive", v, 8'hB4);

    // R9 slave overrun
    c = ctl(0, 0, 0, 0, 1, 0, 1);
    s_setup(c);
    s_xfer(c, 8'h11, 8, 1, got, oe);
    s_xfer(c, 8'h22, 8, 1, got, oe);
    rd(1'b1, v); chk("R9 overrun flag set", v, ctrl_exp(c, 1, 1));
    rd(1'b0, v); chk("R9 slave drop keeps old", v, 8'h11);
    wr(1'b1, c | 8'h02);
    rd(1'b1, v); chk("R9 writing one keeps flag", v, ctrl_exp(c, 0, 1));
    wr(1'b1, c);
    rd(1'b1, v); chk("R9 writing zero clears", v, ctrl_exp(c, 0, 0));

    // R12 partial byte abandoned
    s_xfer(c, 8'hF0, 4, 1, got, oe);
    rd(1'b1, v); chk("R12 partial sets no flag", v, ctrl_exp(c, 0, 0));
    s_xfer(c, 8'h5B, 8, 1, got, oe);
    rd(1'b0, v); chk("R12 fresh byte after abort", v, 8'h5B);

    // random slave
    for (int n = 0; n < 8; n++) begin
      c  = ctl(0, 0, 1'($urandom), 1'($urandom), 1, 0, 1);
      tx = 8'($urandom); rx = 8'($urandom);
      s_setup(c);
      wr(1'b0, tx);
      s_xfer(c, rx, 8, 1, got, oe);
      chk("R10 random slave sdo", got, tx);
      rd(1'b0, v); chk("R10 random slave receive", v, rx);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
  end
endmodule